// File: doc/BRIEF.md
# Banked Memory Target for a Core-Side Command Port

This block is the target end of a point-to-point command interface with a simple request and response protocol. A master drives a command code, an address and write data, and holds them until the block returns a one-cycle accept. A write stores its data and then raises accept. A read raises accept together with a "data valid" response code and the fetched word.

The storage is a row of identical memory banks laid end to end in the address space. The address goes to the first bank. If it lies past the last location of that bank, the first bank stays idle and the request, with the bank's size subtracted, goes to the next bank. This continues along the row. A request that runs past the last bank is still accepted but touches no storage. Address width, data width, bank depth and bank count are parameters.

Each command takes two clock edges. The first edge captures the request. The second edge performs the memory access and raises the accept. The block then returns to idle.

Top module: `ocp_mem_target`

## Requirements
- R1: After reset, `s_cmd_accept` is 0, `s_resp` is 2'b00 and `s_rdata` is zero. Reset returns the request state machine to idle. Memory contents are undefined after reset.
- R2: Command code 3'b000 is idle, 3'b001 is write and 3'b010 is read. Every other code (3'b011 to 3'b111) is treated as idle: it is never accepted and changes no stored word.
- R3: A write of data D to address A stores D at A. Its accept is a single-cycle pulse in the cycle after the second rising edge at which the command is presented. During that pulse `s_resp` stays 2'b00.
- R4: A read of address A raises `s_cmd_accept`, `s_resp` = 2'b01 and `s_rdata` = the word stored at A, all in the same single cycle. That cycle is the one after the second rising edge at which the command is presented.
- R5: Accept and the 2'b01 response last one cycle only. The block is idle in that cycle and samples a new command at the next edge, so back-to-back commands each complete in two edges.
- R6: `s_rdata` is zero in every cycle in which `s_resp` is not 2'b01. It is constant throughout the cycle in which `s_resp` is 2'b01.
- R7: Address A selects bank A / BANK_DEPTH at offset A mod BANK_DEPTH. A bank passes any address at or beyond its own depth on to the next bank and stays idle itself. Words in different banks are independent, including the words on either side of a bank boundary.
- R8: An address of NUM_BANKS*BANK_DEPTH or more is accepted with the normal timing. A write to such an address is discarded. A read from it returns `s_resp` = 2'b01 with zero data.
- R9: Changes on `m_cmd`, `m_addr` and `m_wdata` after a command has been captured, and before its accept, have no effect. The access uses the values captured at the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_cmd | input | 3 | Command code from master (000 idle, 001 write, 010 read) |
| m_addr | input | ADDR_W | Word address from master |
| m_wdata | input | DATA_W | Write data from master |
| s_cmd_accept | output | 1 | One-cycle accept of the current command |
| s_resp | output | 2 | Response code: 00 none, 01 data valid |
| s_rdata | output | DATA_W | Read data, valid while response is 01 |

## Verification
Three kinds of internal fault show up at the ports. A request latch or state machine that sticks or skips a state makes accept arrive early, late, twice or never, and a per-cycle reference model flags this in the very cycle expected. A wrong offset in the bank chain, or a bank that claims an address it should pass on, corrupts a stored word. That fault is only visible when the word is read back, so each bank boundary and the region past the last bank are written with distinct patterns and then read. A read register that is not cleared leaves stale data on `s_rdata` in the cycle right after the valid response.

// File: rtl/ocp_mem_pkg.sv
package ocp_mem_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE  = 3'b000,
        CMD_WRITE = 3'b001,
        CMD_READ  = 3'b010
    } cmd_e;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'b00,
        RSP_VALID = 2'b01
    } resp_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BUSY = 2'b01
    } state_e;

endpackage

// File: rtl/ocp_req_fsm.sv
module ocp_req_fsm
    import ocp_mem_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        m_cmd,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              acc_o,
    output logic [1:0]        resp_o,
    output logic              strobe_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);

    typedef struct packed {
        state_e            state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wr;
        logic              acc;
        resp_e             resp;
    } fsm_t;

    fsm_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.acc  = 1'b0;
        nxt_d.resp = RSP_NONE;
        unique case (cur_q.state)
            ST_BUSY: begin
                nxt_d.state = ST_IDLE;
                nxt_d.acc   = 1'b1;
                nxt_d.resp  = cur_q.wr ? RSP_NONE : RSP_VALID;
            end
            default: begin
                if (m_cmd == CMD_WRITE || m_cmd == CMD_READ) begin
                    nxt_d.state = ST_BUSY;
                    nxt_d.addr  = m_addr;
                    nxt_d.wdata = m_wdata;
                    nxt_d.wr    = (m_cmd == CMD_WRITE);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, addr: '0, wdata: '0, wr: 1'b0,
                       acc: 1'b0, resp: RSP_NONE};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign acc_o    = cur_q.acc;
    assign resp_o   = cur_q.resp;
    assign strobe_o = (cur_q.state == ST_BUSY);
    assign wr_o     = cur_q.wr;
    assign addr_o   = cur_q.addr;
    assign wdata_o  = cur_q.wdata;

endmodule

// File: rtl/ocp_mem_bank.sv
module ocp_mem_bank #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    // storage has no reset: contents are undefined until written
    always_ff @(posedge clk) begin
        if (sel_i && wr_i) begin
            mem_q[idx_i] <= wdata_i;
        end
    end

    // read register holds a word only for the cycle after a selected read
    always_comb begin
        rdata_d = '0;
        if (sel_i && !wr_i) begin
            rdata_d = mem_q[idx_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/ocp_mem_target.sv
module ocp_mem_target #(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int BANK_DEPTH = 16,
    parameter int NUM_BANKS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        m_cmd,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              s_cmd_accept,
    output logic [1:0]        s_resp,
    output logic [DATA_W-1:0] s_rdata
);

    localparam int IDX_W = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;
    localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(BANK_DEPTH);

    logic              strobe, wr;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;

    ocp_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .m_cmd    (m_cmd),
        .m_addr   (m_addr),
        .m_wdata  (m_wdata),
        .acc_o    (s_cmd_accept),
        .resp_o   (s_resp),
        .strobe_o (strobe),
        .wr_o     (wr),
        .addr_o   (req_addr),
        .wdata_o  (req_wdata)
    );

    // offset and activity ripple along the row of banks
    logic [ADDR_W-1:0] off  [NUM_BANKS+1];
    logic              live [NUM_BANKS+1];
    logic [DATA_W-1:0] rd_bank [NUM_BANKS];

    assign off[0]  = req_addr;
    assign live[0] = strobe;

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        logic hit;
        assign hit         = live[k] && (off[k] < DEPTH_A);
        assign live[k+1]   = live[k] && !hit;
        assign off[k+1]    = off[k] - DEPTH_A;

        ocp_mem_bank #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH), .IDX_W(IDX_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_i   (hit),
            .wr_i    (wr),
            .idx_i   (off[k][IDX_W-1:0]),
            .wdata_i (req_wdata),
            .rdata_o (rd_bank[k])
        );
    end

    // at most one bank holds a nonzero read word in any cycle
    always_comb begin
        s_rdata = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            s_rdata = s_rdata | rd_bank[k];
        end
    end

endmodule

// File: rtl/ocp_mem_target_chk.sv
module ocp_mem_target_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        m_cmd,
    input logic              s_cmd_accept,
    input logic [1:0]        s_resp,
    input logic [DATA_W-1:0] s_rdata
);

    // R5: accept never lasts two cycles
    a_r5_accept_single: assert property (@(posedge clk) disable iff (!rst_n)
        s_cmd_accept |=> !s_cmd_accept);

    // R4: data-valid response only together with accept
    a_r4_valid_with_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (s_resp == 2'b01) |-> s_cmd_accept);

    // R6: read data is zero outside a valid response
    a_r6_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (s_resp != 2'b01) |-> (s_rdata == '0));

    // R2: accept follows a legal command captured two edges earlier
    a_r2_legal_cmd_only: assert property (@(posedge clk) disable iff (!rst_n)
        s_cmd_accept |-> ($past(m_cmd, 2) == 3'b001 || $past(m_cmd, 2) == 3'b010));

    // R3: a write is accepted without a data-valid response
    a_r3_write_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (s_cmd_accept && $past(m_cmd, 2) == 3'b001) |-> (s_resp == 2'b00));

    // R4: a read is accepted with the data-valid response
    a_r4_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (s_cmd_accept && $past(m_cmd, 2) == 3'b010) |-> (s_resp == 2'b01));

endmodule

bind ocp_mem_target ocp_mem_target_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .m_cmd        (m_cmd),
    .s_cmd_accept (s_cmd_accept),
    .s_resp       (s_resp),
    .s_rdata      (s_rdata)
);

// File: tb/sim_ocp_mem_target.sv
module sim_ocp_mem_target;

    localparam int AW    = 13;
    localparam int DW    = 8;
    localparam int DEP   = 16;
    localparam int NB    = 4;
    localparam int TOTAL = DEP * NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    m_cmd = 3'b000;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic          s_cmd_accept;
    logic [1:0]    s_resp;
    logic [DW-1:0] s_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    ocp_mem_target #(.ADDR_W(AW), .DATA_W(DW), .BANK_DEPTH(DEP), .NUM_BANKS(NB)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .m_cmd        (m_cmd),
        .m_addr       (m_addr),
        .m_wdata      (m_wdata),
        .s_cmd_accept (s_cmd_accept),
        .s_resp       (s_resp),
        .s_rdata      (s_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: one pending request, a sparse word store
    logic [DW-1:0] ref_mem [int];
    bit            m_busy = 0;
    bit            m_wr = 0;
    int            m_a = 0;
    logic [DW-1:0] m_d = '0;
    bit            e_acc = 0;
    int            e_resp = 0;
    int            e_data = 0;
    bit            e_known = 1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; e_acc = 0; e_resp = 0; e_data = 0; e_known = 1;
        end else begin
            e_acc = 0; e_resp = 0; e_data = 0; e_known = 1;
            if (m_busy) begin
                m_busy = 0;
                e_acc = 1;
                if (m_wr) begin
                    if (m_a < TOTAL) ref_mem[m_a] = m_d;
                end else begin
                    e_resp = 1;
                    if (m_a >= TOTAL) e_data = 0;
                    else if (ref_mem.exists(m_a)) e_data = int'(ref_mem[m_a]);
                    else e_known = 0;
                end
            end else if (m_cmd == 3'b001 || m_cmd == 3'b010) begin
                m_busy = 1;
                m_wr = (m_cmd == 3'b001);
                m_a = int'(m_addr);
                m_d = m_wdata;
            end
        end
    end

    // compared on every clock, away from the rising edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(s_cmd_accept == e_acc, "R5 accept per-cycle", int'(s_cmd_accept), int'(e_acc));
            chk(int'(s_resp) == e_resp, "R4 resp per-cycle", int'(s_resp), e_resp);
            if (e_known) chk(int'(s_rdata) == e_data, "R6 rdata per-cycle", int'(s_rdata), e_data);
        end
    end

    // one command; scramble alters inputs after capture (R9)
    task automatic xfer(input logic [2:0] c, input int a, input int d,
                        input bit scramble, input string req, output int rd);
        int n;
        m_cmd = c; m_addr = AW'(a); m_wdata = DW'(d);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (scramble && n == 1) begin
                m_addr = m_addr ^ AW'(5); m_wdata = ~m_wdata;
                m_cmd = (c == 3'b001) ? 3'b010 : 3'b001;
            end
        end while (!s_cmd_accept && n < 8);
        chk(n == 2, req, n, 2);
        rd = int'(s_rdata);
        if (c == 3'b010) chk(s_resp == 2'b01, req, int'(s_resp), 1);
        else chk(s_resp == 2'b00, req, int'(s_resp), 0);
        m_cmd = 3'b000;
    endtask

    task automatic wr_word(input int a, input int d, input string req);
        int rd;
        xfer(3'b001, a, d, 0, req, rd);
    endtask

    task automatic rd_expect(input int a, input int exp, input string req);
        int rd;
        xfer(3'b010, a, 0, 0, req, rd);
        chk(rd == exp, req, rd, exp);
    endtask

    initial begin
        int rd;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(s_cmd_accept == 1'b0, "R1 accept", int'(s_cmd_accept), 0);
        chk(s_resp == 2'b00, "R1 resp", int'(s_resp), 0);
        chk(s_rdata == '0, "R1 rdata", int'(s_rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;

        // R3, R7: writes across bank boundaries
        wr_word(0, 8'h11, "R3 write b0 low");
        wr_word(DEP-1, 8'h22, "R3 write b0 top");
        wr_word(DEP, 8'h33, "R7 write b1 low");
        wr_word(2*DEP+7, 8'h44, "R7 write b2");
        wr_word(TOTAL-1, 8'h55, "R7 write last");
        // R4, R7: read back
        rd_expect(DEP, 8'h33, "R7 read b1 low");
        rd_expect(DEP-1, 8'h22, "R7 read b0 top");
        rd_expect(0, 8'h11, "R4 read b0 low");
        rd_expect(2*DEP+7, 8'h44, "R4 read b2");
        rd_expect(TOTAL-1, 8'h55, "R4 read last");

        // R5: back to back, no idle gap between commands
        for (int i = 0; i < 6; i++) wr_word(8 + i * 9, 8'hA0 + i, "R5 back-to-back write");
        for (int i = 0; i < 6; i++) rd_expect(8 + i * 9, 8'hA0 + i, "R5 back-to-back read");

        // R2: unlisted codes are idle and alter nothing
        for (int c = 3; c < 8; c++) begin
            m_cmd = 3'(c); m_addr = AW'(0); m_wdata = 8'hEE;
            repeat (3) begin
                @(negedge clk);
                chk(s_cmd_accept == 1'b0, "R2 no accept on unlisted code", int'(s_cmd_accept), 0);
            end
        end
        m_cmd = 3'b000;
        @(negedge clk);
        rd_expect(0, 8'h11, "R2 word unchanged");

        // R8: beyond the last bank
        wr_word(TOTAL, 8'h99, "R8 write beyond");
        wr_word(8191, 8'h98, "R8 write top address");
        rd_expect(TOTAL, 0, "R8 read beyond gives zero");
        rd_expect(8191, 0, "R8 read top gives zero");
        rd_expect(0, 8'h11, "R8 bank0 not aliased");
        rd_expect(TOTAL-1, 8'h55, "R8 last word intact");

        // R9: inputs changed while busy are ignored
        xfer(3'b001, 20, 8'h5A, 1, "R9 write scrambled", rd);
        m_cmd = 3'b000;
        @(negedge clk);
        rd_expect(20, 8'h5A, "R9 captured data stored");
        rd_expect(20 ^ 5, 8'hA0 + 1, "R9 other word untouched");
        xfer(3'b010, 20, 0, 1, "R9 read scrambled", rd);
        chk(rd == 8'h5A, "R9 read uses captured address", rd, 8'h5A);
        m_cmd = 3'b000;

        // R6: data quiet after valid cycle
        @(negedge clk);
        chk(s_rdata == '0, "R6 rdata cleared", int'(s_rdata), 0);
        repeat (3) @(negedge clk);

        // R1: reset mid-stream returns to idle
        m_cmd = 3'b010; m_addr = AW'(0);
        @(negedge clk);
        cmp_on = 1'b0;
        rst_n = 1'b0; m_cmd = 3'b000;
        @(negedge clk);
        chk(s_cmd_accept == 1'b0, "R1 accept in reset", int'(s_cmd_accept), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(s_cmd_accept == 1'b0, "R1 no accept after reset", int'(s_cmd_accept), 0);
        chk(s_resp == 2'b00, "R1 resp after reset", int'(s_resp), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule